// File: doc/BRIEF.md
# Legacy Replacement Interrupt Router

This block sits between a set of timer channels and a chip's interrupt lines. Each channel raises an event. The router turns that event into a held level or a one-cycle pulse on one of 32 interrupt lines, chosen by the channel's route selector. A channel can instead be set to message delivery. Its event then becomes a 32-bit data write to a 32-bit address, and both values are taken from a 64-bit per-channel message register. The router also forwards two external legacy interrupt sources, an interval timer and a real-time clock, onto lines 0 and 8. It drives an enable output that tells the external interval timer whether it may run.

A single mode input selects legacy replacement. When the mode is set, channel 0 takes over line 0 and channel 1 takes over line 8, and both external sources are blocked. Entering or leaving the mode runs a short sequence on the affected lines and on the timer enable. The clock input is sampled every cycle, even while it is blocked. On leaving the mode, line 8 is restored from that remembered value. All line and enable outputs are registered, so they change one clock edge after their inputs.

Top module: `lrr_router`

## Requirements
- R1: Outside legacy mode, an active line-routed channel raises the line whose index equals its 5-bit route selector. The line is raised at the next clock edge, and each line is the OR of every source mapped to it.
- R2: In legacy mode, channel 0 drives line 0 and channel 1 drives line 8 whatever their route selectors hold. Channels 2 and up keep using their route selectors.
- R3: The external interval-timer input reaches line 0, and the external clock input reaches line 8, only while legacy mode is off.
- R4: On the first cycle with the mode input high after it was low, lines 0 and 8 are driven low and the timer enable output goes low. The enable stays low while the mode lasts.
- R5: On the first cycle with the mode input low after it was high, line 0 is driven low and the timer enable goes high. Line 8 takes the clock input level captured on the previous edge; that level is captured every cycle, including during legacy mode.
- R6: A channel whose level flag is 1 latches its event as pending and holds its line until its clear input is pulsed. A channel whose level flag is 0 raises its line for exactly one cycle per event.
- R7: A channel with its message flag set drives no line and drops any pending line interrupt it holds.
- R8: An event on a message-flagged channel produces one write request. The address is bits 63:32 and the data bits 31:0 of that channel's message register, taken when the request is loaded. Waiting events are served lowest channel index first, and none is lost.
- R9: A write request stays valid, with address and data unchanged, until it is accepted by ready being high.
- R10: During and right after reset all lines are low, the timer enable is high, no write request is valid and the remembered clock level is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_set_i | input | N_CH | Per-channel event strobe |
| ch_clr_i | input | N_CH | Per-channel pending clear strobe |
| ch_level_i | input | N_CH | Per-channel level (1) or pulse (0) flag |
| ch_msg_en_i | input | N_CH | Per-channel message delivery flag |
| ch_route_sel_i | input | 5*N_CH | Per-channel line selector, channel c at bits 5c+4:5c |
| ch_msg_reg_i | input | 64*N_CH | Per-channel message register: address high half, data low half |
| legacy_i | input | 1 | Legacy replacement mode |
| ext_pit_i | input | 1 | External interval-timer interrupt |
| ext_rtc_i | input | 1 | External real-time clock interrupt |
| irq_o | output | 32 | Interrupt lines |
| pit_en_o | output | 1 | Enable for the external interval timer |
| msg_valid_o | output | 1 | Write request valid |
| msg_ready_i | input | 1 | Write request accepted |
| msg_addr_o | output | 32 | Write address |
| msg_data_o | output | 32 | Write data |

## Verification
The hardest situation to reach is the exit from legacy mode while the clock input has changed during the mode. Only that path shows that line 8 takes the remembered level rather than the live one. Channels routed to lines 0 and 8 must also be active at the transition edge, so that the forced lowering can be seen. The stimulus toggles the mode at random short intervals and flips the clock input independently. Route selectors are biased toward lines 0 and 8. A directed opening sequence latches a level interrupt and then switches its channel to message delivery while ready is held low. This shows both the dropped pending line and a stalled request.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
    localparam int ROUTE_W   = 5;
    localparam int N_LINES   = 1 << ROUTE_W;
    localparam int MSG_W     = 64;
    localparam int HALF_W    = MSG_W / 2;
    localparam int LEG_LINE0 = 0;
    localparam int LEG_LINE1 = 8;
endpackage

// File: rtl/lrr_chan_slot.sv
module lrr_chan_slot
    import lrr_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               set_i,
    input  logic               clr_i,
    input  logic               level_i,
    input  logic               msg_en_i,
    output logic               act_o,
    output logic               msg_evt_o
);
    typedef struct packed {
        logic pend;
    } slot_st_t;

    slot_st_t s_d, s_q;
    logic     held;

    always_comb begin
        s_d       = s_q;
        held      = s_q.pend & ~clr_i;
        if (msg_en_i) begin
            s_d.pend = 1'b0;
        end else begin
            s_d.pend = held | (set_i & level_i);
        end
        act_o     = ~msg_en_i & (held | set_i);
        msg_evt_o = msg_en_i & set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R6: a latched level request survives until cleared
    p_level_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.pend && !clr_i && !msg_en_i) |=> s_q.pend);

    // R7: message delivery leaves nothing pending on the line side
    p_msg_drops_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_en_i |=> !s_q.pend);
endmodule

// File: rtl/lrr_line_map.sv
module lrr_line_map
    import lrr_pkg::*;
#(
    parameter int N_CH = 3
) (
    input  logic [N_CH-1:0]         act_i,
    input  logic [N_CH*ROUTE_W-1:0] route_i,
    input  logic                    legacy_i,
    input  logic                    pit_i,
    input  logic                    rtc_i,
    input  logic                    rtc_mem_i,
    input  logic                    enter_i,
    input  logic                    leave_i,
    output logic [N_LINES-1:0]      lines_o
);
    always_comb begin : map_blk
        logic [ROUTE_W-1:0] dst;
        lines_o = '0;
        for (int c = 0; c < N_CH; c++) begin
            dst = route_i[c*ROUTE_W +: ROUTE_W];
            if (legacy_i && c == 0) dst = ROUTE_W'(LEG_LINE0);
            if (legacy_i && c == 1) dst = ROUTE_W'(LEG_LINE1);
            if (act_i[c]) lines_o[dst] = 1'b1;
        end
        if (!legacy_i) begin
            lines_o[LEG_LINE0] = lines_o[LEG_LINE0] | pit_i;
            lines_o[LEG_LINE1] = lines_o[LEG_LINE1] | rtc_i;
        end
        if (enter_i) begin
            lines_o[LEG_LINE0] = 1'b0;
            lines_o[LEG_LINE1] = 1'b0;
        end
        if (leave_i) begin
            lines_o[LEG_LINE0] = 1'b0;
            lines_o[LEG_LINE1] = rtc_mem_i;
        end
    end
endmodule

// File: rtl/lrr_msg_issue.sv
module lrr_msg_issue
    import lrr_pkg::*;
#(
    parameter int N_CH = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [N_CH-1:0]       evt_i,
    input  logic [N_CH*MSG_W-1:0] msg_reg_i,
    input  logic                  ready_i,
    output logic                  valid_o,
    output logic [HALF_W-1:0]     addr_o,
    output logic [HALF_W-1:0]     data_o
);
    typedef struct packed {
        logic [N_CH-1:0]   pend;
        logic              valid;
        logic [HALF_W-1:0] addr;
        logic [HALF_W-1:0] data;
    } iss_st_t;

    iss_st_t         s_d, s_q;
    logic [N_CH-1:0] pool;
    logic [N_CH-1:0] grant;

    always_comb begin
        s_d   = s_q;
        pool  = s_q.pend | evt_i;
        grant = '0;
        if (!s_q.valid || ready_i) begin
            s_d.valid = 1'b0;
            for (int c = N_CH - 1; c >= 0; c--) begin
                if (pool[c]) begin
                    grant    = '0;
                    grant[c] = 1'b1;
                end
            end
            for (int c = 0; c < N_CH; c++) begin
                if (grant[c]) begin
                    s_d.valid = 1'b1;
                    s_d.addr  = msg_reg_i[c*MSG_W + HALF_W +: HALF_W];
                    s_d.data  = msg_reg_i[c*MSG_W +: HALF_W];
                end
            end
        end
        s_d.pend = pool & ~grant;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign valid_o = s_q.valid;
    assign addr_o  = s_q.addr;
    assign data_o  = s_q.data;

    // R9: a stalled request keeps its payload
    p_stall_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));

    // R8: an event is never dropped
    p_evt_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> (s_q.valid || (|s_q.pend)));
endmodule

// File: rtl/lrr_router.sv
module lrr_router
    import lrr_pkg::*;
#(
    parameter int N_CH = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [N_CH-1:0]       ch_set_i,
    input  logic [N_CH-1:0]       ch_clr_i,
    input  logic [N_CH-1:0]       ch_level_i,
    input  logic [N_CH-1:0]       ch_msg_en_i,
    input  logic [N_CH*5-1:0]     ch_route_sel_i,
    input  logic [N_CH*64-1:0]    ch_msg_reg_i,
    input  logic                  legacy_i,
    input  logic                  ext_pit_i,
    input  logic                  ext_rtc_i,
    output logic [31:0]           irq_o,
    output logic                  pit_en_o,
    output logic                  msg_valid_o,
    input  logic                  msg_ready_i,
    output logic [31:0]           msg_addr_o,
    output logic [31:0]           msg_data_o
);
    typedef struct packed {
        logic [N_LINES-1:0] irq;
        logic               pit_en;
        logic               rtc_mem;
        logic               mode;
    } top_st_t;

    top_st_t            s_d, s_q;
    logic [N_CH-1:0]    act;
    logic [N_CH-1:0]    msg_evt;
    logic [N_LINES-1:0] lines;
    logic               enter, leave;

    assign enter = legacy_i & ~s_q.mode;
    assign leave = ~legacy_i & s_q.mode;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        lrr_chan_slot u_slot (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .set_i     (ch_set_i[c]),
            .clr_i     (ch_clr_i[c]),
            .level_i   (ch_level_i[c]),
            .msg_en_i  (ch_msg_en_i[c]),
            .act_o     (act[c]),
            .msg_evt_o (msg_evt[c])
        );
    end

    lrr_line_map #(.N_CH(N_CH)) u_map (
        .act_i     (act),
        .route_i   (ch_route_sel_i),
        .legacy_i  (legacy_i),
        .pit_i     (ext_pit_i),
        .rtc_i     (ext_rtc_i),
        .rtc_mem_i (s_q.rtc_mem),
        .enter_i   (enter),
        .leave_i   (leave),
        .lines_o   (lines)
    );

    lrr_msg_issue #(.N_CH(N_CH)) u_msg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (msg_evt),
        .msg_reg_i (ch_msg_reg_i),
        .ready_i   (msg_ready_i),
        .valid_o   (msg_valid_o),
        .addr_o    (msg_addr_o),
        .data_o    (msg_data_o)
    );

    always_comb begin
        s_d         = s_q;
        s_d.irq     = lines;
        s_d.mode    = legacy_i;
        s_d.rtc_mem = ext_rtc_i;
        if (enter)      s_d.pit_en = 1'b0;
        else if (leave) s_d.pit_en = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q        <= '0;
            s_q.pit_en <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o    = s_q.irq;
    assign pit_en_o = s_q.pit_en;

    // R4: mode entry lowers both shared lines and gates the timer
    p_enter_seq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (legacy_i && !s_q.mode) |=> (!pit_en_o && !irq_o[LEG_LINE0] && !irq_o[LEG_LINE1]));

    // R5: mode exit restores the remembered clock level
    p_exit_seq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!legacy_i && s_q.mode) |=> (pit_en_o && !irq_o[LEG_LINE0]
                                     && (irq_o[LEG_LINE1] == $past(s_q.rtc_mem))));

    // R2: channel 0 owns line 0 during a steady legacy mode
    p_leg_ch0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (legacy_i && s_q.mode && act[0]) |=> irq_o[LEG_LINE0]);
endmodule

// File: tb/lrr_router_tb_top.sv
module lrr_router_tb_top;
    localparam int N = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    set_s = '0, clr_s = '0, lvl_s = '0, men_s = '0;
    logic [N*5-1:0]  rsel = '0;
    logic [N*64-1:0] mreg = '0;
    logic            leg = 1'b0, pit = 1'b0, rtc = 1'b0, rdy = 1'b1;
    logic [31:0]     irq, maddr, mdata;
    logic            pit_en, mvalid;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lrr_router #(.N_CH(N)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ch_set_i(set_s), .ch_clr_i(clr_s),
        .ch_level_i(lvl_s), .ch_msg_en_i(men_s), .ch_route_sel_i(rsel),
        .ch_msg_reg_i(mreg), .legacy_i(leg), .ext_pit_i(pit), .ext_rtc_i(rtc),
        .irq_o(irq), .pit_en_o(pit_en), .msg_valid_o(mvalid),
        .msg_ready_i(rdy), .msg_addr_o(maddr), .msg_data_o(mdata)
    );

    // behavioural reference model
    bit        m_pend[N];
    bit        m_mq[$];
    bit        m_mwait[N];
    bit        m_mode, m_pit = 1, m_rtc;
    bit [31:0] m_irq, m_ma, m_md;
    bit        m_mv;
    string     t_irq = "R10", t_pit = "R10", t_msg = "R10";

    always @(posedge clk) begin : model
        bit [31:0] ln;
        bit        en, lv, hold_seen, drop_seen;
        int        dst, g;
        if (!rst_n) begin
            foreach (m_pend[c]) begin m_pend[c] = 0; m_mwait[c] = 0; end
            m_mode = 0; m_pit = 1; m_rtc = 0; m_irq = 0; m_mv = 0;
            m_ma = 0; m_md = 0;
            t_irq = "R10"; t_pit = "R10"; t_msg = "R10";
        end else begin
            en = leg && !m_mode;
            lv = !leg && m_mode;
            ln = 0; hold_seen = 0; drop_seen = 0;
            for (int c = 0; c < N; c++) begin
                if (men_s[c] && m_pend[c]) drop_seen = 1;
                if (!men_s[c] && m_pend[c] && !clr_s[c]) hold_seen = 1;
                if (!men_s[c] && ((m_pend[c] && !clr_s[c]) || set_s[c])) begin
                    dst = rsel[c*5 +: 5];
                    if (leg && c == 0) dst = 0;
                    if (leg && c == 1) dst = 8;
                    ln[dst] = 1;
                end
                m_pend[c] = men_s[c] ? 0 : ((m_pend[c] && !clr_s[c]) || (set_s[c] && lvl_s[c]));
                if (men_s[c] && set_s[c]) m_mwait[c] = 1;
            end
            if (!leg) begin ln[0] |= pit; ln[8] |= rtc; end
            if (en) begin ln[0] = 0; ln[8] = 0; end
            if (lv) begin ln[0] = 0; ln[8] = m_rtc; end
            if (en)      t_irq = "R4";
            else if (lv) t_irq = "R5";
            else if (drop_seen) t_irq = "R7";
            else if (hold_seen) t_irq = "R6";
            else if (leg) t_irq = "R2";
            else if (pit || rtc) t_irq = "R3";
            else t_irq = "R1";
            m_irq = ln;
            if (en) begin m_pit = 0; t_pit = "R4"; end
            else if (lv) begin m_pit = 1; t_pit = "R5"; end
            else t_pit = leg ? "R4" : "R5";
            m_rtc = rtc;
            m_mode = leg;
            if (!m_mv || rdy) begin
                m_mv = 0; g = -1;
                for (int c = 0; c < N; c++) if (m_mwait[c] && g < 0) g = c;
                if (g >= 0) begin
                    m_mv = 1; m_mwait[g] = 0;
                    m_ma = mreg[g*64 + 32 +: 32];
                    m_md = mreg[g*64 +: 32];
                end
                t_msg = "R8";
            end else begin
                t_msg = "R9";
            end
        end
    end

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(t_irq, "irq lines", irq, m_irq);
        check(t_pit, "timer enable", {31'd0, pit_en}, {31'd0, m_pit});
        check(t_msg, "request valid", {31'd0, mvalid}, {31'd0, m_mv});
        if (m_mv) begin
            check(t_msg, "request addr", maddr, m_ma);
            check(t_msg, "request data", mdata, m_md);
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        set_s = '0; clr_s = '0;
    endtask

    function automatic logic [4:0] pick_route();
        int r = $urandom_range(0, 3);
        if (r == 0) return 5'd0;
        if (r == 1) return 5'd8;
        return 5'($urandom_range(0, 31));
    endfunction

    initial begin : stim
        int next_toggle;
        repeat (3) @(negedge clk);
        check("R10", "reset irq", irq, 32'd0);
        check("R10", "reset timer enable", {31'd0, pit_en}, 32'd1);
        check("R10", "reset valid", {31'd0, mvalid}, 32'd0);
        rst_n = 1'b1;
        step();
        check("R10", "post-reset irq", irq, 32'd0);
        for (int c = 0; c < N; c++) mreg[c*64 +: 64] = {$urandom, $urandom};
        // directed: level latch on ch0 then switch it to message delivery
        rsel[0 +: 5] = 5'd5; lvl_s[0] = 1'b1; set_s[0] = 1'b1;
        step(); step(); step(); step();
        rdy = 1'b0; men_s[0] = 1'b1; set_s[0] = 1'b1;
        step(); step(); step();
        rdy = 1'b1; men_s[0] = 1'b0;
        step(); step();
        // directed: legacy entry and exit with the clock input flipping inside
        rtc = 1'b1; pit = 1'b1; step();
        leg = 1'b1; step(); step();
        rtc = 1'b0; step();
        rtc = 1'b1; step();
        leg = 1'b0; rtc = 1'b0; step(); step();
        // random phase
        next_toggle = 20;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc % 37 == 0) begin
                for (int c = 0; c < N; c++) begin
                    rsel[c*5 +: 5] = pick_route();
                    lvl_s[c] = 1'($urandom_range(0, 1));
                    men_s[c] = ($urandom_range(0, 3) == 0);
                    mreg[c*64 +: 64] = {$urandom, $urandom};
                end
            end
            for (int c = 0; c < N; c++) begin
                set_s[c] = ($urandom_range(0, 5) == 0);
                clr_s[c] = ($urandom_range(0, 7) == 0);
            end
            pit = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 5) == 0) rtc = ~rtc;
            rdy = ($urandom_range(0, 3) != 0);
            if (cyc >= 400 && cyc == next_toggle) begin
                leg = ~leg;
                next_toggle = cyc + $urandom_range(2, 30);
            end else if (cyc < 400) begin
                next_toggle = 400;
            end
            @(negedge clk);
            compare_all();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule